// File: doc/BRIEF.md
# Audio Mute and Fade Level Controller

This block scales a stream of 16-bit signed audio samples by a gain held in a 7-bit fade counter. A gain of zero silences the output, and the top counter value passes samples through unchanged. Each output sample is the input times the counter value, divided by the counter maximum and truncated toward zero. The result is registered, so it appears one clock after the sample is presented.

A host changes the gain by writing a 4-bit command with a one-cycle write strobe. Preset commands load mute, a fixed attenuation of about -12 dB (counter value 32), or full scale. Step commands move the counter one position up or down and stop at either end. The host repeats step commands to produce a smooth fade. After reset the block is muted. A `muted` output reports when the counter is zero.

Top module: `audio_fade_ctrl`

## Requirements
- R1: After reset the fade counter is 0, `muted` is 1 and `sampleOut` is 0.
- R2: A write with cmdData[2:0] = 000 loads counter 0 (mute), so the output is zero.
- R3: A write with cmdData[2:0] = 001, 010 or 011 loads the attenuation level, 32 by default.
- R4: A write with cmdData[2:0] = 110 or 111 loads the counter maximum, 127, so the output equals the input.
- R5: A write with cmdData[2:0] = 101 raises the counter by one. At 127 the counter stays at 127.
- R6: A write with cmdData[2:0] = 100 lowers the counter by one. At 0 the counter stays at 0.
- R7: cmdData[3] has no effect on any command.
- R8: `sampleOut` equals sampleIn × counter / 127, truncated toward zero. It is computed from the sample and counter present at one rising edge and is visible after that edge.
- R9: `muted` is 1 exactly when the counter is 0.
- R10: cmdData has no effect while cmdWr is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWr | input | 1 | One-cycle command write strobe |
| cmdData | input | 4 | Command code; bit 3 is don't-care |
| sampleIn | input | 16 | Signed input sample |
| sampleOut | output | 16 | Signed scaled sample, registered |
| muted | output | 1 | High when the fade counter is zero |

## Verification
Each counter value is made visible by applying the sample 32767. The quotient 32767 × g / 127 is different for every g, so any error in a preset or a step appears at the output. At the attenuation level, small positive and negative samples separate truncation toward zero from floor rounding. The extremes -32768 and 32767 at full scale expose sign-extension and overflow faults. Step runs that push past both ends of the counter confirm that it saturates instead of wrapping. Repeating each preset with bit 3 set, and presenting codes with the strobe low, confirms that neither changes the counter.

// File: rtl/audio_fade_pkg.sv
package audio_fade_pkg;

  // Strobes from the command decoder to the gain datapath
  typedef struct packed {
    logic loadMute;
    logic loadAtten;
    logic loadFull;
    logic stepUp;
    logic stepDown;
  } fadeStrobes_t;

  // Command encodings on cmdData[2:0]; bit 3 is ignored
  localparam logic [2:0] CODE_MUTE = 3'b000;
  localparam logic [2:0] CODE_DOWN = 3'b100;
  localparam logic [2:0] CODE_UP   = 3'b101;

endpackage

// File: rtl/audio_fade_decode.sv
module audio_fade_decode
  import audio_fade_pkg::*;
(
  input  logic         cmdWr,
  input  logic [3:0]   cmdData,
  output fadeStrobes_t strobes
);

  logic [2:0] code;
  assign code = cmdData[2:0];

  always_comb begin
    strobes = '0;
    if (cmdWr) begin
      unique casez (code)
        CODE_MUTE: strobes.loadMute  = 1'b1;
        3'b001,
        3'b01?:    strobes.loadAtten = 1'b1;
        CODE_DOWN: strobes.stepDown  = 1'b1;
        CODE_UP:   strobes.stepUp    = 1'b1;
        3'b11?:    strobes.loadFull  = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/audio_fade_datapath.sv
module audio_fade_datapath
  import audio_fade_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 7,
  parameter int ATTEN_LEVEL = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fadeStrobes_t               strobes,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic        [GAIN_W-1:0]   gainLevel,
  output logic                       muted
);

  localparam int                PROD_W   = SAMPLE_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
  localparam logic [GAIN_W-1:0] GAIN_ATT = GAIN_W'(ATTEN_LEVEL);
  localparam logic signed [PROD_W-1:0] DIVISOR = PROD_W'(GAIN_MAX);

  logic                     atTop;
  logic                     atBottom;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] quotient;

  assign atTop    = (gainLevel == GAIN_MAX);
  assign atBottom = (gainLevel == '0);

  // Bounded fade counter: presets win over steps, steps saturate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainLevel <= '0;
    end else if (strobes.loadMute) begin
      gainLevel <= '0;
    end else if (strobes.loadAtten) begin
      gainLevel <= GAIN_ATT;
    end else if (strobes.loadFull) begin
      gainLevel <= GAIN_MAX;
    end else if (strobes.stepUp && !atTop) begin
      gainLevel <= gainLevel + 1'b1;
    end else if (strobes.stepDown && !atBottom) begin
      gainLevel <= gainLevel - 1'b1;
    end
  end

  // Signed scaling; signed division truncates toward zero
  always_comb begin
    product  = PROD_W'(sampleIn) * $signed({1'b0, gainLevel});
    quotient = product / DIVISOR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else begin
      sampleOut <= quotient[SAMPLE_W-1:0];
    end
  end

  assign muted = atBottom;

endmodule

// File: rtl/audio_fade_ctrl.sv
module audio_fade_ctrl
  import audio_fade_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 7,
  parameter int ATTEN_LEVEL = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWr,
  input  logic [3:0]          cmdData,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                muted
);

  fadeStrobes_t       strobes;
  logic [GAIN_W-1:0]  gainLevel;

  audio_fade_decode u_decode (
    .cmdWr   (cmdWr),
    .cmdData (cmdData),
    .strobes (strobes)
  );

  audio_fade_datapath #(
    .SAMPLE_W    (SAMPLE_W),
    .GAIN_W      (GAIN_W),
    .ATTEN_LEVEL (ATTEN_LEVEL)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .sampleOut (sampleOut),
    .gainLevel (gainLevel),
    .muted     (muted)
  );

endmodule

// File: rtl/audio_fade_chk.sv
module audio_fade_chk #(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 7,
  parameter int ATTEN_LEVEL = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdWr,
  input logic [3:0]          cmdData,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic [GAIN_W-1:0]   gainLevel
);

  localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};
  localparam logic [GAIN_W-1:0] GATT = GAIN_W'(ATTEN_LEVEL);

  // R2
  mute_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] == 3'b000) |=> (gainLevel == '0));

  // R3
  atten_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (cmdData[2:0] == 3'b001 || cmdData[2:1] == 2'b01)) |=> (gainLevel == GATT));

  // R4
  full_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:1] == 2'b11) |=> (gainLevel == GMAX));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] == 3'b101 && gainLevel != GMAX)
      |=> (gainLevel == $past(gainLevel) + 1'b1));

  // R5
  top_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] == 3'b101 && gainLevel == GMAX) |=> (gainLevel == GMAX));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] == 3'b100 && gainLevel != '0)
      |=> (gainLevel == $past(gainLevel) - 1'b1));

  // R6
  bottom_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] == 3'b100 && gainLevel == '0) |=> (gainLevel == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> $stable(gainLevel));

  // R8
  silent_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gainLevel == '0) |=> (sampleOut == '0));

endmodule

bind audio_fade_ctrl audio_fade_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .GAIN_W      (GAIN_W),
  .ATTEN_LEVEL (ATTEN_LEVEL)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWr     (cmdWr),
  .cmdData   (cmdData),
  .sampleOut (sampleOut),
  .gainLevel (gainLevel)
);

// File: tb/audio_fade_ctrl_tb.sv
module audio_fade_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [3:0]  cmdData = 4'd0;
  logic [15:0] sampleIn = 16'd0;
  logic [15:0] sampleOut;
  logic        muted;

  int vecCount = 0;
  int errCount = 0;
  int modelGain = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  audio_fade_ctrl u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWr     (cmdWr),
    .cmdData   (cmdData),
    .sampleIn  (sampleIn),
    .sampleOut (sampleOut),
    .muted     (muted)
  );

  function automatic int expOut(int s, int g);
    int mag;
    mag = ((s < 0) ? -s : s) * g / 127;
    return (s < 0) ? -mag : mag;
  endfunction

  task automatic sendCmd(input logic [3:0] code);
    @(negedge clk);
    cmdWr = 1'b1;
    cmdData = code;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  // Present one sample, then compare output and muted after the capturing edge
  task automatic checkSample(input int s, input string req);
    int want;
    @(negedge clk);
    sampleIn = 16'(s);
    @(posedge clk);
    @(negedge clk);
    want = expOut(s, modelGain);
    vecCount++;
    if ($signed(sampleOut) != want || muted != (modelGain == 0)) begin
      errCount++;
      $display("FAIL %s: sampleOut=%0d muted=%0b expected %0d muted=%0b",
               req, $signed(sampleOut), muted, want, (modelGain == 0));
    end
  endtask

  task automatic testReset();
    vecCount++;
    if (sampleOut != 16'd0 || muted != 1'b1) begin
      errCount++;
      $display("FAIL R1: sampleOut=%0d muted=%0b expected 0 muted=1", sampleOut, muted);
    end
    checkSample(32767, "R1");
  endtask

  task automatic testPresets();
    sendCmd(4'b0110); modelGain = 127; checkSample(32767, "R4");
    checkSample(-32768, "R4");
    sendCmd(4'b0001); modelGain = 32; checkSample(32767, "R3");
    sendCmd(4'b0111); modelGain = 127; checkSample(-12345, "R4");
    sendCmd(4'b0010); modelGain = 32; checkSample(32767, "R3");
    sendCmd(4'b0000); modelGain = 0; checkSample(32767, "R2 R9");
    sendCmd(4'b0011); modelGain = 32; checkSample(32767, "R3");
  endtask

  task automatic testScaling();
    sendCmd(4'b0001); modelGain = 32;
    checkSample(100, "R8");
    checkSample(-100, "R8");
    checkSample(-1, "R8");
    checkSample(-32768, "R8");
    checkSample(0, "R8");
  endtask

  task automatic testStepUp();
    sendCmd(4'b0110); modelGain = 127;
    for (int i = 0; i < 3; i++) begin
      sendCmd(4'b1101);
      checkSample(32767, "R5 saturate top");
    end
    sendCmd(4'b0001); modelGain = 32;
    for (int i = 0; i < 4; i++) begin
      sendCmd(4'b0101); modelGain++;
      checkSample(32767, "R5");
    end
  endtask

  task automatic testStepDown();
    sendCmd(4'b0110); modelGain = 127;
    sendCmd(4'b0100); modelGain = 126; checkSample(32767, "R6");
    sendCmd(4'b0000); modelGain = 0;
    sendCmd(4'b0101); modelGain = 1; checkSample(32767, "R5 R9");
    sendCmd(4'b0100); modelGain = 0; checkSample(32767, "R6 R9");
    sendCmd(4'b0100); checkSample(32767, "R6 saturate bottom");
  endtask

  task automatic testBit3();
    sendCmd(4'b1110); modelGain = 127; checkSample(20000, "R7");
    sendCmd(4'b1000); modelGain = 0; checkSample(20000, "R7");
    sendCmd(4'b1011); modelGain = 32; checkSample(20000, "R7");
    sendCmd(4'b1100); modelGain = 31; checkSample(20000, "R7");
  endtask

  task automatic testNoWrite();
    sendCmd(4'b0001); modelGain = 32;
    @(negedge clk);
    cmdData = 4'b0000;
    @(negedge clk);
    cmdData = 4'b0110;
    @(negedge clk);
    cmdData = 4'b0101;
    checkSample(32767, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    checkSample(-5000, "R1");
    testPresets();
    testScaling();
    testStepUp();
    testStepDown();
    testBit3();
    testNoWrite();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

endmodule